// File: doc/BRIEF.md
# Pulse-Width Single-Wire Serial Transmitter

This block sends a packet of bytes over one shared, open-drain data wire. Every data bit takes a fixed slot of four microseconds. The slot starts with the wire pulled low and ends with the wire released. The value of the bit is set by how the slot is divided. A one uses a short low phase and a long released phase. A zero uses a long low phase and a short released phase. The block never drives the wire high. It only asserts an output-enable, `line_pull`, which makes an external driver, whose output is fixed at zero, pull the wire low. A pull-up supplies the high level whenever that enable is off.

Bytes enter through a valid/ready port. Each beat carries a last-byte flag and an empty flag. A one-byte holding register lets the producer deliver the next byte while the current one is on the wire, so bits follow each other with no gap. After the final bit of the last byte, the block adds a short low stop pulse, releases the wire and pulses `tx_done` for one cycle. A beat marked empty stands for a request to send zero bytes. It is consumed and produces no line activity. Slot timing comes from the parameter `CLK_PER_US`, which gives clock cycles per microsecond. A short phase lasts `CLK_PER_US` cycles and a long phase lasts `3*CLK_PER_US` cycles.

Control is a Moore state machine with these states:
- IDLE: line released, waiting for a held byte.
- PULL: the low phase of a bit.
- RELEASE: the released phase of a bit. This phase is extended while the next byte is missing.
- STOP: the low stop pulse.
- FINISH: the one-cycle done state.

The transitions are:
- start: IDLE to PULL.
- pull_end: PULL to RELEASE.
- next_bit, and next_byte: RELEASE to PULL.
- starve: RELEASE to RELEASE.
- close: RELEASE to STOP.
- stop_end: STOP to FINISH.
- rearm: FINISH to IDLE.

Top module: `pwire_tx`

## Requirements
- R1: During and right after reset, `line_pull`, `tx_busy` and `tx_done` are 0 and `in_ready` is 1.
- R2: A 0 bit asserts `line_pull` for exactly 3*CLK_PER_US cycles, followed by a release of CLK_PER_US cycles.
- R3: A 1 bit asserts `line_pull` for exactly CLK_PER_US cycles, followed by a release of 3*CLK_PER_US cycles.
- R4: Within a byte, bit 7 goes out first and bit 0 last. Bytes go out in the order they were accepted.
- R5: When the next byte is already held at the end of a slot, the next low phase starts in the following cycle. The period from one falling edge to the next is then exactly 4*CLK_PER_US cycles.
- R6: After the last bit of the byte flagged last, `line_pull` asserts for CLK_PER_US cycles as a stop pulse and then releases.
- R7: `tx_done` is high for exactly one cycle: the first cycle after the stop pulse releases. `tx_busy` is 0 in that cycle.
- R8: `tx_busy` is 1 from the first cycle of the first low phase through the last cycle of the stop pulse.
- R9: A beat with `in_empty`=1 is consumed (in_ready stays 1) and is discarded. It causes no `line_pull`, no `tx_busy` and no `tx_done`, whatever its last flag.
- R10: Once a non-empty byte with `in_last`=1 is accepted, `in_ready` stays 0 until the cycle after `tx_done`. The holding register takes only one byte at a time.
- R11: If the next byte of an unfinished packet is not held when a slot ends, the wire stays released and `tx_busy` stays 1 until a byte arrives. The next bit then starts normally.
- R12: `line_pull` is never asserted while `tx_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_data | input | DATA_W | Byte to send |
| in_last | input | 1 | Beat is the final byte of the packet |
| in_empty | input | 1 | Beat carries no data (zero-byte request) |
| in_ready | output | 1 | Block accepts a beat this cycle |
| line_pull | output | 1 | Output-enable: 1 pulls the wire low, 0 releases it |
| tx_busy | output | 1 | Packet in progress on the wire |
| tx_done | output | 1 | One-cycle pulse after the stop bit |

## Verification
The hardest case to reach from the ports is the starved released phase. The producer has to stay silent across a whole slot boundary in the middle of a packet. The stimulus does this by handing over a byte with the last flag clear and then withholding the next byte for longer than a full byte time. The bench then checks that the wire is released while busy is still high. When the late byte finally arrives, the decoded bits must still come out in order. The no-gap case is reached in the opposite way: the driver feeds the next byte as soon as ready rises, so every slot boundary is measured with the holding register already full.

// File: rtl/pwire_pkg.sv
package pwire_pkg;
    typedef enum logic [2:0] {
        PW_IDLE,
        PW_PULL,
        PW_RELEASE,
        PW_STOP,
        PW_FINISH
    } pw_state_t;
endpackage

// File: rtl/pwire_hold.sv
module pwire_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_empty,
    input  logic              take,
    input  logic              clear,
    output logic              in_ready,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_last
);
    logic closed;
    logic accept;

    assign in_ready = !hold_valid && !closed;
    assign accept   = in_valid && in_ready && !in_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            hold_last  <= 1'b0;
            closed     <= 1'b0;
        end else begin
            if (accept) begin
                hold_valid <= 1'b1;
                hold_data  <= in_data;
                hold_last  <= in_last;
                if (in_last) closed <= 1'b1;
            end else if (take) begin
                hold_valid <= 1'b0;
            end
            if (clear) closed <= 1'b0;
        end
    end

    // R10: an accepted byte is held until the state machine takes it
    assert_hold_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !take) |=> hold_valid);
endmodule

// File: rtl/pwire_timer.sv
module pwire_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pwire_shift.sv
module pwire_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic              at_last
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] sr;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            idx <= '0;
        end else if (load) begin
            sr  <= load_data;
            idx <= '0;
        end else if (shift) begin
            sr  <= sr << 1;
            idx <= idx + 1'b1;
        end
    end

    assign cur_bit = sr[DATA_W-1];
    assign nxt_bit = sr[DATA_W-2];
    assign at_last = (idx == LAST_IDX);

    // R4: no shift past the final bit of a byte
    assert_no_overshift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !at_last);
endmodule

// File: rtl/pwire_tx.sv
module pwire_tx
    import pwire_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CLK_PER_US = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_empty,
    output logic              in_ready,
    output logic              line_pull,
    output logic              tx_busy,
    output logic              tx_done
);
    localparam int LONG_N  = 3 * CLK_PER_US;
    localparam int SHORT_N = CLK_PER_US;
    localparam int CNT_W   = (LONG_N > 1) ? $clog2(LONG_N) : 1;
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_N - 1);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_N - 1);

    pw_state_t state, state_d;

    logic              hold_valid, hold_last;
    logic [DATA_W-1:0] hold_data;
    logic              take, clear;
    logic              tmr_load, expired;
    logic [CNT_W-1:0]  tmr_val;
    logic              sh_load, sh_shift;
    logic              cur_bit, nxt_bit, at_last;
    logic              cur_last;

    pwire_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_empty   (in_empty),
        .take       (take),
        .clear      (clear),
        .in_ready   (in_ready),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .hold_last  (hold_last)
    );

    pwire_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    pwire_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (hold_data),
        .shift     (sh_shift),
        .cur_bit   (cur_bit),
        .nxt_bit   (nxt_bit),
        .at_last   (at_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PW_IDLE;
            cur_last <= 1'b0;
        end else begin
            state <= state_d;
            if (sh_load) cur_last <= hold_last;
        end
    end

    // next state and datapath control
    always_comb begin
        state_d  = state;
        tmr_load = 1'b0;
        tmr_val  = LEN_SHORT;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        take     = 1'b0;
        clear    = 1'b0;
        unique case (state)
            PW_IDLE: begin
                if (hold_valid) begin            // start
                    sh_load  = 1'b1;
                    take     = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = hold_data[DATA_W-1] ? LEN_SHORT : LEN_LONG;
                    state_d  = PW_PULL;
                end
            end
            PW_PULL: begin
                if (expired) begin               // pull_end
                    tmr_load = 1'b1;
                    tmr_val  = cur_bit ? LEN_LONG : LEN_SHORT;
                    state_d  = PW_RELEASE;
                end
            end
            PW_RELEASE: begin
                if (expired) begin
                    if (!at_last) begin          // next_bit
                        sh_shift = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = nxt_bit ? LEN_SHORT : LEN_LONG;
                        state_d  = PW_PULL;
                    end else if (cur_last) begin // close
                        tmr_load = 1'b1;
                        tmr_val  = LEN_SHORT;
                        state_d  = PW_STOP;
                    end else if (hold_valid) begin // next_byte
                        sh_load  = 1'b1;
                        take     = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = hold_data[DATA_W-1] ? LEN_SHORT : LEN_LONG;
                        state_d  = PW_PULL;
                    end                          // else starve
                end
            end
            PW_STOP: begin
                if (expired) state_d = PW_FINISH; // stop_end
            end
            PW_FINISH: begin
                clear   = 1'b1;                  // rearm
                state_d = PW_IDLE;
            end
            default: state_d = PW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        line_pull = 1'b0;
        tx_busy   = 1'b0;
        tx_done   = 1'b0;
        unique case (state)
            PW_IDLE:    ;
            PW_PULL:    begin line_pull = 1'b1; tx_busy = 1'b1; end
            PW_RELEASE: tx_busy = 1'b1;
            PW_STOP:    begin line_pull = 1'b1; tx_busy = 1'b1; end
            PW_FINISH:  tx_done = 1'b1;
            default:    ;
        endcase
    end

    // low-run length watcher for the pulse-width assertion
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)         low_run <= '0;
        else if (line_pull) low_run <= low_run + 1'b1;
        else                low_run <= '0;
    end

    // R2, R3, R6: every low pulse is either short or long
    assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pull && low_run != '0) |->
        (low_run == (CNT_W+1)'(SHORT_N) || low_run == (CNT_W+1)'(LONG_N)));

    assert_pull_needs_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> tx_busy);

    assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(line_pull) && !tx_busy && !line_pull));

    assert_ready_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !in_empty) |=> !in_ready);

    assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !tx_done && !hold_valid && in_valid && in_empty) |=> !tx_busy);
endmodule

// File: tb/sim_pwire_tx.sv
module sim_pwire_tx;
    localparam int US   = 16;
    localparam int DW   = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_last, in_empty;
    logic [DW-1:0] in_data;
    logic          in_ready, line_pull, tx_busy, tx_done;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit strict = 1'b1;

    always #4 clk = ~clk;

    pwire_tx #(.DATA_W(DW), .CLK_PER_US(US)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_empty  (in_empty),
        .in_ready  (in_ready),
        .line_pull (line_pull),
        .tx_busy   (tx_busy),
        .tx_done   (tx_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: decodes pulses and compares against the scoreboard queue
    bit prev_pull = 1'b0, prev_done = 1'b0, have_bit = 1'b0;
    int low_len = 0, hi_len = 0, last_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_done && prev_done) check("R7 done width", 2, 1);
            if (line_pull && !tx_busy) check("R8 busy during pull", 0, 1);
            if (tx_done && tx_busy) check("R7 busy at done", 1, 0);
            if (line_pull) begin
                if (!prev_pull) begin
                    if (have_bit && strict)
                        check("R5 slot period", last_low + hi_len, 4 * US);
                    low_len = 1;
                end else begin
                    low_len++;
                end
            end else begin
                if (prev_pull) begin
                    int got;
                    if (tx_done) got = 2;
                    else if (low_len == US) got = 1;
                    else if (low_len == 3 * US) got = 0;
                    else got = 9;
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected pulse", got, -1);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check("R2/R3/R4 decoded item", got, e);
                    end
                    if (got == 2) check("R6 stop width", low_len, US);
                    have_bit = (got != 2);
                    last_low = low_len;
                    hi_len   = 1;
                end else begin
                    hi_len++;
                end
            end
            prev_pull = line_pull;
            prev_done = tx_done;
        end
    end

    // driver: pushes expected bits, then hands the byte over
    task automatic send_byte(input logic [DW-1:0] b, input logic last);
        for (int i = DW - 1; i >= 0; i--) exp_q.push_back(int'(b[i]));
        if (last) exp_q.push_back(2);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        in_empty = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!tx_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R7 done seen", int'(tx_done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R1-related run hung)");
        finish_sim();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_empty = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 pull in reset", int'(line_pull), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pull", int'(line_pull), 0);
        check("R1 busy", int'(tx_busy), 0);
        check("R1 done", int'(tx_done), 0);
        check("R1 ready", int'(in_ready), 1);

        // single byte, mixed bits (R2, R3, R4, R6)
        send_byte(8'hA5, 1'b1);
        wait_done();
        @(negedge clk);
        check("R10 ready after done", int'(in_ready), 1);
        check("R4 queue drained", exp_q.size(), 0);

        // back-to-back bytes (R5, R10)
        send_byte(8'h00, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h3C, 1'b1);
        check("R10 ready closed after last", int'(in_ready), 0);
        wait_done();
        @(negedge clk);
        check("R10 ready reopened", int'(in_ready), 1);
        check("R5 queue drained", exp_q.size(), 0);

        // empty beat (R9)
        in_valid = 1'b1; in_empty = 1'b1; in_last = 1'b1; in_data = 8'hFF;
        check("R9 ready for empty beat", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0; in_empty = 1'b0; in_last = 1'b0;
        begin
            int act = 0;
            for (int i = 0; i < 200; i++) begin
                if (line_pull || tx_busy || tx_done) act++;
                @(negedge clk);
            end
            check("R9 no activity", act, 0);
        end
        check("R9 ready after empty", int'(in_ready), 1);

        // starved packet (R11)
        strict = 1'b0;
        send_byte(8'h81, 1'b0);
        repeat (700) @(negedge clk);
        check("R11 busy while starved", int'(tx_busy), 1);
        check("R11 line released", int'(line_pull), 0);
        send_byte(8'h7E, 1'b1);
        wait_done();
        strict = 1'b1;
        @(negedge clk);
        check("R11 queue drained", exp_q.size(), 0);
        check("R12 idle release", int'(line_pull), 0);

        finish_sim();
    end
endmodule